// File: doc/BRIEF.md
# Power-Up Sequencing Controller

This block runs from the 32 kHz sleep clock. It takes a two-processor system from power-off to running in a fixed order. Four wake sources are synchronized and qualified: a power key, a charger detect, a real-time-clock alarm and a voltage detect on an external bus line. The rising edge of any qualified source raises the master release line. That line powers the first regulator group and the sleep-clock output buffer. After a settle interval the controller enables the application-side I/O rail, then the core rail, then the PLL rail. Each rail is enabled only when the previous one has returned its ready handshake. Power-OK follows the last ready.

After a long hold interval the processors are released from reset. A short staged delay later, the warm-reset-complete indication goes high. A watchdog-expiry input, or loss of the software keep-alive once the processors run, returns every output to off. A rail that never reports ready within a bounded wait puts the controller into a fault state. That state stays quiet until a fresh wake edge arrives.

Top module: `pwrseq_ctrl`

## Requirements
- R1: While and after reset, every output (main_rel_o, io_en_o, core_en_o, pll_en_o, sclk_fwd_o, pwr_ok_o, proc_rel_o, warm_done_o, fault_o) is low.
- R2: A rising edge on wake_chg_i, wake_rtc_i or wake_bus_i raises main_rel_o on the third clock edge after the input rises (two synchronizer flops plus the state register).
- R3: wake_key_i counts only after KEY_SAMPLES (default 3) consecutive synchronized high samples: a 2-cycle pulse leaves main_rel_o low, and a pulse of 3 or more cycles raises it.
- R4: io_en_o rises exactly APE_DLY (default 22) cycles after main_rel_o rises.
- R5: core_en_o and sclk_fwd_o rise together one cycle after io_rdy_i is seen high while io_en_o is high, and never before.
- R6: pll_en_o rises one cycle after core_rdy_i is seen high while core_en_o is high. pwr_ok_o rises one cycle after pll_rdy_i is seen high while pll_en_o is high.
- R7: proc_rel_o rises exactly PG_DLY (default 524) cycles after pwr_ok_o rises.
- R8: warm_done_o rises exactly WARM_CYC (default 5) cycles after proc_rel_o rises.
- R9: wdog_expire_i high while main_rel_o is high drives all outputs low on the next cycle.
- R10: sw_keep_alive_i low while proc_rel_o is high drives all outputs low on the next cycle.
- R11: A rail left unready for RDY_TMO (default 255) cycles after its enable rises drives fault_o high and every enable and release output low. A later wake edge clears fault_o and restarts the sequence.
- R12: Wake sources are edge-qualified, so a wake input still held high after a shutdown does not restart the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_slp | input | 1 | 32.768 kHz sleep clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wake_key_i | input | 1 | Power key, asynchronous, debounced |
| wake_chg_i | input | 1 | Charger detect, asynchronous |
| wake_rtc_i | input | 1 | RTC alarm, asynchronous |
| wake_bus_i | input | 1 | External bus voltage detect, asynchronous |
| sw_keep_alive_i | input | 1 | Software keep-alive, must stay high while running |
| wdog_expire_i | input | 1 | Watchdog expiry, forces power-off |
| io_rdy_i | input | 1 | I/O rail ready handshake |
| core_rdy_i | input | 1 | Core rail ready handshake |
| pll_rdy_i | input | 1 | PLL rail ready handshake |
| main_rel_o | output | 1 | Master release: first regulator group and sleep-clock buffer |
| io_en_o | output | 1 | I/O rail enable |
| core_en_o | output | 1 | Core rail enable |
| pll_en_o | output | 1 | PLL rail enable |
| sclk_fwd_o | output | 1 | Sleep clock forwarded to the second processor |
| pwr_ok_o | output | 1 | Second-domain power complete |
| proc_rel_o | output | 1 | Processor reset release |
| warm_done_o | output | 1 | Warm-reset-complete indication |
| fault_o | output | 1 | Rail ready timeout occurred |

## Verification
The assertions assume that rail ready inputs are level handshakes, synchronous to the sleep clock. They also assume that watchdog expiry and keep-alive come from logic in the same clock domain. They do not assume that a ready arrives at any particular time, so timeouts are legal. The bench changes every input half a cycle away from the active edge. It raises each ready only after the matching enable has been observed, and it keeps keep-alive high until the loss-of-keep-alive case is exercised on purpose.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

   typedef enum logic [2:0] {
      ST_OFF,
      ST_SETTLE,
      ST_IO,
      ST_CORE,
      ST_PLL,
      ST_HOLD,
      ST_RUN,
      ST_FAULT
   } pseq_state_e;

   function automatic int unsigned bits_for(input int unsigned v);
      return (v < 2) ? 1 : $clog2(v + 1);
   endfunction

endpackage

// File: rtl/pwrseq_wake.sv
module pwrseq_wake #(
   parameter int unsigned NSRC        = 4,
   parameter int unsigned KEY_SAMPLES = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] raw_i,
   output logic            evt_o
);
   localparam int unsigned KW = pwrseq_pkg::bits_for(KEY_SAMPLES);
   localparam logic [KW-1:0] KEY_FULL = KW'(KEY_SAMPLES);

   logic [NSRC-1:0] qual;
   logic [NSRC-1:0] qual_q;

   for (genvar i = 0; i < NSRC; i++) begin : g_src
      logic s1_q, s2_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
         end else begin
            s1_q <= raw_i[i];
            s2_q <= s1_q;
         end
      end

      if (i == 0) begin : g_deb
         logic [KW-1:0] run_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                run_q <= '0;
            else if (!s2_q)            run_q <= '0;
            else if (run_q != KEY_FULL) run_q <= run_q + 1'b1;
         end
         assign qual[i] = (run_q == KEY_FULL);
      end else begin : g_plain
         assign qual[i] = s2_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) qual_q <= '0;
      else        qual_q <= qual;
   end

   assign evt_o = |(qual & ~qual_q);

endmodule

// File: rtl/pwrseq_tmr.sv
module pwrseq_tmr #(
   parameter int unsigned W = 10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   output logic [W-1:0] cnt_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_o <= '0;
      else if (clr_i)  cnt_o <= '0;
      else if (!(&cnt_o)) cnt_o <= cnt_o + 1'b1;
   end
endmodule

// File: rtl/pwrseq_warm.sv
module pwrseq_warm #(
   parameter int unsigned STAGES = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic done_o
);
   logic [STAGES-1:0] sr_q;

   if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sr_q <= '0;
         else        sr_q <= start_i;
      end
   end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        sr_q <= '0;
         else if (!start_i) sr_q <= '0;
         else               sr_q <= {sr_q[STAGES-2:0], 1'b1};
      end
   end

   assign done_o = sr_q[STAGES-1] & start_i;
endmodule

// File: rtl/pwrseq_ctrl.sv
module pwrseq_ctrl #(
   parameter int unsigned APE_DLY     = 22,
   parameter int unsigned PG_DLY      = 524,
   parameter int unsigned RDY_TMO     = 255,
   parameter int unsigned WARM_CYC    = 5,
   parameter int unsigned KEY_SAMPLES = 3
) (
   input  logic clk_slp,
   input  logic rst_n,
   input  logic wake_key_i,
   input  logic wake_chg_i,
   input  logic wake_rtc_i,
   input  logic wake_bus_i,
   input  logic sw_keep_alive_i,
   input  logic wdog_expire_i,
   input  logic io_rdy_i,
   input  logic core_rdy_i,
   input  logic pll_rdy_i,
   output logic main_rel_o,
   output logic io_en_o,
   output logic core_en_o,
   output logic pll_en_o,
   output logic sclk_fwd_o,
   output logic pwr_ok_o,
   output logic proc_rel_o,
   output logic warm_done_o,
   output logic fault_o
);
   import pwrseq_pkg::*;

   localparam int unsigned MAXI = (PG_DLY > APE_DLY) ?
                                  ((PG_DLY > RDY_TMO) ? PG_DLY : RDY_TMO) :
                                  ((APE_DLY > RDY_TMO) ? APE_DLY : RDY_TMO);
   localparam int unsigned CW = bits_for(MAXI);
   localparam logic [CW-1:0] APE_LAST = CW'(APE_DLY - 1);
   localparam logic [CW-1:0] PG_LAST  = CW'(PG_DLY - 1);
   localparam logic [CW-1:0] TMO_LAST = CW'(RDY_TMO - 1);

   if (APE_DLY < 1 || PG_DLY < 1 || RDY_TMO < 1) begin : g_bad_dly
      $error("pwrseq_ctrl: interval parameters must be at least 1");
   end
   if (WARM_CYC < 1 || KEY_SAMPLES < 1) begin : g_bad_stage
      $error("pwrseq_ctrl: WARM_CYC and KEY_SAMPLES must be at least 1");
   end

   pseq_state_e st_q, st_d;
   logic        wake_evt;
   logic [CW-1:0] cnt;
   logic        powered;

   pwrseq_wake #(.NSRC(4), .KEY_SAMPLES(KEY_SAMPLES)) u_wake (
      .clk   (clk_slp),
      .rst_n (rst_n),
      .raw_i ({wake_bus_i, wake_rtc_i, wake_chg_i, wake_key_i}),
      .evt_o (wake_evt)
   );

   pwrseq_tmr #(.W(CW)) u_tmr (
      .clk   (clk_slp),
      .rst_n (rst_n),
      .clr_i (st_d != st_q),
      .cnt_o (cnt)
   );

   assign powered = (st_q != ST_OFF) && (st_q != ST_FAULT);

   always_comb begin
      st_d = st_q;
      if (powered && wdog_expire_i) begin
         st_d = ST_OFF;
      end else begin
         unique case (st_q)
            ST_OFF, ST_FAULT: if (wake_evt) st_d = ST_SETTLE;
            ST_SETTLE: if (cnt == APE_LAST) st_d = ST_IO;
            ST_IO: begin
               if (io_rdy_i)              st_d = ST_CORE;
               else if (cnt == TMO_LAST)  st_d = ST_FAULT;
            end
            ST_CORE: begin
               if (core_rdy_i)            st_d = ST_PLL;
               else if (cnt == TMO_LAST)  st_d = ST_FAULT;
            end
            ST_PLL: begin
               if (pll_rdy_i)             st_d = ST_HOLD;
               else if (cnt == TMO_LAST)  st_d = ST_FAULT;
            end
            ST_HOLD: if (cnt == PG_LAST) st_d = ST_RUN;
            ST_RUN:  if (!sw_keep_alive_i) st_d = ST_OFF;
            default: st_d = ST_OFF;
         endcase
      end
   end

   always_ff @(posedge clk_slp or negedge rst_n) begin
      if (!rst_n) st_q <= ST_OFF;
      else        st_q <= st_d;
   end

   assign main_rel_o = powered;
   assign io_en_o    = (st_q == ST_IO)   || (st_q == ST_CORE) || (st_q == ST_PLL) ||
                       (st_q == ST_HOLD) || (st_q == ST_RUN);
   assign core_en_o  = (st_q == ST_CORE) || (st_q == ST_PLL) ||
                       (st_q == ST_HOLD) || (st_q == ST_RUN);
   assign sclk_fwd_o = core_en_o;
   assign pll_en_o   = (st_q == ST_PLL) || (st_q == ST_HOLD) || (st_q == ST_RUN);
   assign pwr_ok_o   = (st_q == ST_HOLD) || (st_q == ST_RUN);
   assign proc_rel_o = (st_q == ST_RUN);
   assign fault_o    = (st_q == ST_FAULT);

   pwrseq_warm #(.STAGES(WARM_CYC)) u_warm (
      .clk     (clk_slp),
      .rst_n   (rst_n),
      .start_i (proc_rel_o),
      .done_o  (warm_done_o)
   );

endmodule

// File: rtl/pwrseq_ctrl_chk.sv
module pwrseq_ctrl_chk (
   input logic clk_slp,
   input logic rst_n,
   input logic sw_keep_alive_i,
   input logic wdog_expire_i,
   input logic io_rdy_i,
   input logic core_rdy_i,
   input logic pll_rdy_i,
   input logic main_rel_o,
   input logic io_en_o,
   input logic core_en_o,
   input logic pll_en_o,
   input logic sclk_fwd_o,
   input logic pwr_ok_o,
   input logic proc_rel_o,
   input logic warm_done_o,
   input logic fault_o
);
   AST_IO_AFTER_MAIN: assert property (@(posedge clk_slp) disable iff (!rst_n)
      $rose(io_en_o) |-> $past(main_rel_o)); // R4
   AST_CORE_NEEDS_IO: assert property (@(posedge clk_slp) disable iff (!rst_n)
      $rose(core_en_o) |-> $past(io_rdy_i) && $past(io_en_o) && sclk_fwd_o); // R5
   AST_PLL_NEEDS_CORE: assert property (@(posedge clk_slp) disable iff (!rst_n)
      $rose(pll_en_o) |-> $past(core_rdy_i)); // R6
   AST_PWROK_NEEDS_PLL: assert property (@(posedge clk_slp) disable iff (!rst_n)
      $rose(pwr_ok_o) |-> $past(pll_rdy_i)); // R6
   AST_REL_AFTER_PWROK: assert property (@(posedge clk_slp) disable iff (!rst_n)
      $rose(proc_rel_o) |-> $past(pwr_ok_o)); // R7
   AST_WARM_UNDER_REL: assert property (@(posedge clk_slp) disable iff (!rst_n)
      $rose(warm_done_o) |-> $past(proc_rel_o)); // R8
   AST_WDOG_OFF: assert property (@(posedge clk_slp) disable iff (!rst_n)
      (wdog_expire_i && main_rel_o) |=> !main_rel_o && !io_en_o && !proc_rel_o); // R9
   AST_KEEPALIVE_OFF: assert property (@(posedge clk_slp) disable iff (!rst_n)
      (proc_rel_o && !sw_keep_alive_i) |=> !main_rel_o && !proc_rel_o && !warm_done_o); // R10
   AST_FAULT_QUIET: assert property (@(posedge clk_slp) disable iff (!rst_n)
      $rose(fault_o) |-> $past(io_en_o) && !main_rel_o && !io_en_o); // R11
endmodule

bind pwrseq_ctrl pwrseq_ctrl_chk u_chk (
   .clk_slp         (clk_slp),
   .rst_n           (rst_n),
   .sw_keep_alive_i (sw_keep_alive_i),
   .wdog_expire_i   (wdog_expire_i),
   .io_rdy_i        (io_rdy_i),
   .core_rdy_i      (core_rdy_i),
   .pll_rdy_i       (pll_rdy_i),
   .main_rel_o      (main_rel_o),
   .io_en_o         (io_en_o),
   .core_en_o       (core_en_o),
   .pll_en_o        (pll_en_o),
   .sclk_fwd_o      (sclk_fwd_o),
   .pwr_ok_o        (pwr_ok_o),
   .proc_rel_o      (proc_rel_o),
   .warm_done_o     (warm_done_o),
   .fault_o         (fault_o)
);

// File: tb/pwrseq_ctrl_tb.sv
module pwrseq_ctrl_tb_top;
   localparam time CLK_PERIOD = 30518ns;
   localparam int  APE = 22, PG = 524, TMO = 255, WARM = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [3:0] wake = '0;  // bit0 key, bit1 chg, bit2 rtc, bit3 bus
   logic keep = 1'b1, wdog = 1'b0, io_rdy = 1'b0, core_rdy = 1'b0, pll_rdy = 1'b0;
   logic main_rel, io_en, core_en, pll_en, sclk_fwd, pwr_ok, proc_rel, warm_done, fault;

   int tests = 0, fails = 0, cyc = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   pwrseq_ctrl dut_i (
      .clk_slp(clk), .rst_n(rst_n),
      .wake_key_i(wake[0]), .wake_chg_i(wake[1]), .wake_rtc_i(wake[2]), .wake_bus_i(wake[3]),
      .sw_keep_alive_i(keep), .wdog_expire_i(wdog),
      .io_rdy_i(io_rdy), .core_rdy_i(core_rdy), .pll_rdy_i(pll_rdy),
      .main_rel_o(main_rel), .io_en_o(io_en), .core_en_o(core_en), .pll_en_o(pll_en),
      .sclk_fwd_o(sclk_fwd), .pwr_ok_o(pwr_ok), .proc_rel_o(proc_rel),
      .warm_done_o(warm_done), .fault_o(fault)
   );

   typedef struct packed {
      logic [1:0] src;
      logic [3:0] len;
      logic       start;
   } vec_t;

   localparam vec_t VECS [7] = '{
      '{src: 2'd1, len: 4'd1, start: 1'b1},   // R2 charger
      '{src: 2'd2, len: 4'd2, start: 1'b1},   // R2 rtc
      '{src: 2'd3, len: 4'd3, start: 1'b1},   // R2 bus
      '{src: 2'd0, len: 4'd1, start: 1'b0},   // R3 key too short
      '{src: 2'd0, len: 4'd2, start: 1'b0},   // R3 key too short
      '{src: 2'd0, len: 4'd3, start: 1'b1},   // R3 key just long enough
      '{src: 2'd0, len: 4'd6, start: 1'b1}    // R3 key long
   };

   task automatic step(input int n = 1);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int all_out();
      return {main_rel, io_en, core_en, pll_en, sclk_fwd, pwr_ok, proc_rel, warm_done, fault};
   endfunction

   task automatic count_until(ref logic sig, output int n);
      n = 0;
      while (!sig && n < 2000) begin
         step();
         n++;
      end
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > 100000 && !done) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
         end
      end
   end

   initial begin
      int n;
      step(3);
      chk(all_out() == 0, "R1 in reset", all_out(), 0);
      rst_n = 1'b1;
      step(2);
      chk(all_out() == 0, "R1 after reset", all_out(), 0);

      // vector table: wake source qualification
      foreach (VECS[k]) begin
         wake[VECS[k].src] = 1'b1;
         step(int'(VECS[k].len));
         wake[VECS[k].src] = 1'b0;
         step(12 - int'(VECS[k].len));
         chk(main_rel == VECS[k].start, (VECS[k].src == 0) ? "R3 key" : "R2 wake",
             main_rel, VECS[k].start);
         wdog = 1'b1;
         step();
         wdog = 1'b0;
         chk(all_out() == 0, "R9 wdog off", all_out(), 0);
         step(3);
      end

      // full sequence via charger, exact latency of R2
      wake[1] = 1'b1;
      step(2);
      chk(main_rel == 1'b0, "R2 not early", main_rel, 0);
      step();
      chk(main_rel == 1'b1, "R2 third edge", main_rel, 1);
      count_until(io_en, n);
      chk(n == APE, "R4 settle", n, APE);
      step(3);
      chk(core_en == 1'b0 && sclk_fwd == 1'b0, "R5 wait io ready", core_en, 0);
      io_rdy = 1'b1;
      step();
      chk(core_en && sclk_fwd, "R5 core after io", {core_en, sclk_fwd}, 3);
      chk(pll_en == 1'b0, "R6 pll waits", pll_en, 0);
      core_rdy = 1'b1;
      step();
      chk(pll_en == 1'b1 && pwr_ok == 1'b0, "R6 pll after core", {pll_en, pwr_ok}, 2);
      pll_rdy = 1'b1;
      step();
      chk(pwr_ok == 1'b1, "R6 pwr ok", pwr_ok, 1);
      count_until(proc_rel, n);
      chk(n == PG, "R7 hold", n, PG);
      count_until(warm_done, n);
      chk(n == WARM, "R8 warm", n, WARM);
      keep = 1'b0;
      step();
      chk(all_out() == 0, "R10 keep-alive lost", all_out(), 0);
      keep = 1'b1;
      io_rdy = 1'b0; core_rdy = 1'b0; pll_rdy = 1'b0;
      step(10);
      chk(main_rel == 1'b0, "R12 held wake ignored", main_rel, 0);
      wake[1] = 1'b0;
      step(3);

      // rail timeout
      wake[2] = 1'b1;
      step(3);
      wake[2] = 1'b0;
      count_until(io_en, n);
      count_until(fault, n);
      chk(n == TMO, "R11 timeout", n, TMO);
      chk(main_rel == 1'b0 && io_en == 1'b0, "R11 fault quiet", {main_rel, io_en}, 0);
      step(5);
      chk(fault == 1'b1, "R11 fault holds", fault, 1);
      wake[3] = 1'b1;
      step(3);
      chk(main_rel == 1'b1 && fault == 1'b0, "R11 restart", {main_rel, fault}, 2);
      wake[3] = 1'b0;
      step(4);
      wdog = 1'b1;
      step();
      wdog = 1'b0;
      chk(all_out() == 0, "R9 wdog in settle", all_out(), 0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule